// File: doc/BRIEF.md
# Parallel Hough Vote Accumulator with Tile Peak Finder

This block holds one slice of a Hough parameter space: a group of theta lanes that work side by side, each owning a vote memory indexed by rho bin. While voting, every lane may receive a rho value on every clock. The lane adds one to that bin's count with a read-modify-write. Counts stop at their maximum value and never wrap. A vote that hits the same bin as the vote just before it still counts, because the pending write value is forwarded.

A single-cycle drain request switches the block into a sweep. All lanes read their bins in ascending rho order and zero each bin as it is read. The counts stream into a peak finder. For each rho it first takes the maximum across lanes, then keeps a running maximum over a tile of consecutive rho bins. When a tile closes, its winner is reported if the count is strictly above a programmable threshold. The report carries the absolute theta index (pass number times lane count plus lane) and the winning rho bin.

A full angle sweep is covered by running one pass per group of lanes and draining between passes. After reset the block runs the same sweep once, without reporting, to put every count at zero.

Top module: `hv_accum`

## Requirements
- R1: After reset, `busy_o` is high for exactly NUM_BINS cycles while every count is zeroed, and no peak is reported. A drain that follows, with threshold 0, reports no peaks.
- R2: A vote on lane L (`vote_vld_i[L]` high, rho on bits [L*RHO_W +: RHO_W] of `vote_rho_i`) adds one to bin (L, rho). Lanes are independent and may all vote in the same cycle.
- R3: Votes to the same lane and bin on consecutive cycles are each counted.
- R4: A count stops at 2^CNT_W-1 (1023 by default) and does not wrap.
- R5: A vote is ignored when its rho is NUM_BINS or more, when `busy_o` is high, or when `drain_start_i` is high in the same cycle.
- R6: `drain_start_i` while idle makes `busy_o` high for exactly NUM_BINS cycles, after which every count is zero. `drain_start_i` while busy is ignored.
- R7: For each tile of TILE consecutive rho bins (tile k covers bins k*TILE to k*TILE+TILE-1), the maximum count over all lanes and bins of the tile is reported only when it is strictly greater than `thresh_i`.
- R8: A tie inside a tile goes to the lowest lane, then to the lowest rho.
- R9: A report gives `peak_theta_o` = `pass_i`*LANES + lane and `peak_rho_o` = the winning bin.
- R10: Reports come out in increasing tile order, at most one per tile, with `peak_vld_o` high for one cycle each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vote_vld_i | input | LANES | Per-lane vote strobe |
| vote_rho_i | input | LANES*RHO_W | Per-lane rho bin, lane L at bits [L*RHO_W +: RHO_W] |
| drain_start_i | input | 1 | Starts a drain-and-clear sweep when idle |
| pass_i | input | PASS_W | Pass number used to form the theta index |
| thresh_i | input | CNT_W | Peak threshold (strictly greater wins) |
| busy_o | output | 1 | High during the power-up clear and during a drain |
| peak_vld_o | output | 1 | One-cycle strobe for a peak report |
| peak_theta_o | output | TH_W | Absolute theta index of the peak |
| peak_rho_o | output | RHO_W | Rho bin of the peak |

## Verification
The bench goes after back-to-back votes to one bin: a design without forwarding would lose votes, and the count would fall to or below the threshold, so the expected peak would be missing. It drives more than 1023 votes into one cell. A wrapping counter would leave a small count that no longer beats a threshold of 1022. Ties across lanes and across rho bins check the tie-break: a design that used >= or scanned in the other direction would report the wrong theta or rho. The bench also votes with out-of-range rho, votes during a drain and pulses drain_start again mid-drain. A design that accepted any of these would show stray peaks in the following drain or a sweep of the wrong length.

// File: rtl/hv_pkg.sv
package hv_pkg;
    typedef enum logic [1:0] {
        HV_IDLE  = 2'd0,
        HV_INIT  = 2'd1,
        HV_DRAIN = 2'd2
    } hv_mode_e;
endpackage

// File: rtl/hv_vote_lane.sv
module hv_vote_lane #(
    parameter int NUM_BINS = 120,
    parameter int CNT_W    = 10,
    parameter int RHO_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vote_en_i,
    input  logic [RHO_W-1:0] vote_rho_i,
    input  logic             sweep_i,
    input  logic [RHO_W-1:0] sweep_addr_i,
    output logic [CNT_W-1:0] rd_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             s1_vld;
        logic [RHO_W-1:0] s1_addr;
        logic             wb_vld;
        logic [RHO_W-1:0] wb_addr;
        logic [CNT_W-1:0] wb_cnt;
    } lane_t;

    lane_t st_d, st_q;

    logic [CNT_W-1:0] mem [NUM_BINS];
    logic [CNT_W-1:0] rd_q;
    logic [CNT_W-1:0] base, inc;
    logic             we, re;
    logic [RHO_W-1:0] wa, ra;
    logic [CNT_W-1:0] wd;

    always_comb begin
        // forward the write made on the edge that also performed this read
        base = (st_q.wb_vld && st_q.wb_addr == st_q.s1_addr) ? st_q.wb_cnt : rd_q;
        inc  = (base == CNT_MAX) ? base : base + 1'b1;

        st_d         = st_q;
        st_d.s1_vld  = vote_en_i;
        st_d.s1_addr = vote_rho_i;
        st_d.wb_vld  = st_q.s1_vld && !sweep_i;
        st_d.wb_addr = st_q.s1_addr;
        st_d.wb_cnt  = inc;

        we = sweep_i || st_q.s1_vld;
        wa = sweep_i ? sweep_addr_i : st_q.s1_addr;
        wd = sweep_i ? '0 : inc;
        re = sweep_i || vote_en_i;
        ra = sweep_i ? sweep_addr_i : vote_rho_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
        if (re) begin
            rd_q <= mem[ra];
        end
    end

    assign rd_cnt_o = rd_q;
endmodule

// File: rtl/hv_peak_finder.sv
module hv_peak_finder #(
    parameter int LANES    = 15,
    parameter int NUM_BINS = 120,
    parameter int TILE     = 15,
    parameter int CNT_W    = 10,
    parameter int RHO_W    = 7,
    parameter int PASS_W   = 5,
    parameter int TH_W     = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dv_i,
    input  logic [RHO_W-1:0]            rho_i,
    input  logic [LANES-1:0][CNT_W-1:0] cnt_i,
    input  logic [PASS_W-1:0]           pass_i,
    input  logic [CNT_W-1:0]            thresh_i,
    output logic                        peak_vld_o,
    output logic [TH_W-1:0]             peak_theta_o,
    output logic [RHO_W-1:0]            peak_rho_o
);
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int TC_W = (TILE > 1) ? $clog2(TILE) : 1;
    localparam logic [RHO_W-1:0] LAST_BIN  = RHO_W'(NUM_BINS - 1);
    localparam logic [TC_W-1:0]  LAST_TILE = TC_W'(TILE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] mx;
        logic [LW-1:0]    lane;
        logic [RHO_W-1:0] rho;
        logic [TC_W-1:0]  tcnt;
        logic             vld;
        logic [TH_W-1:0]  theta;
        logic [RHO_W-1:0] orho;
    } pf_t;

    pf_t pf_d, pf_q;
    logic [CNT_W-1:0] col_mx;
    logic [LW-1:0]    col_lane;

    // stage one: maximum across lanes, lowest lane wins a tie
    always_comb begin
        col_mx   = cnt_i[0];
        col_lane = '0;
        for (int l = 1; l < LANES; l++) begin
            if (cnt_i[l] > col_mx) begin
                col_mx   = cnt_i[l];
                col_lane = LW'(l);
            end
        end
    end

    // stage two: running maximum across the bins of one tile
    always_comb begin
        pf_d     = pf_q;
        pf_d.vld = 1'b0;
        if (dv_i) begin
            if (pf_q.tcnt == '0 || col_mx > pf_q.mx) begin
                pf_d.mx   = col_mx;
                pf_d.lane = col_lane;
                pf_d.rho  = rho_i;
            end
            if (pf_q.tcnt == LAST_TILE || rho_i == LAST_BIN) begin
                pf_d.tcnt = '0;
                if (pf_d.mx > thresh_i) begin
                    pf_d.vld   = 1'b1;
                    pf_d.theta = TH_W'(pass_i) * TH_W'(LANES) + TH_W'(pf_d.lane);
                    pf_d.orho  = pf_d.rho;
                end
            end else begin
                pf_d.tcnt = pf_q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= '0;
        end else begin
            pf_q <= pf_d;
        end
    end

    assign peak_vld_o   = pf_q.vld;
    assign peak_theta_o = pf_q.theta;
    assign peak_rho_o   = pf_q.orho;
endmodule

// File: rtl/hv_accum.sv
module hv_accum #(
    parameter int LANES      = 15,
    parameter int NUM_BINS   = 120,
    parameter int TILE       = 15,
    parameter int CNT_W      = 10,
    parameter int NUM_PASSES = 21,
    parameter int RHO_W      = $clog2(NUM_BINS),
    parameter int PASS_W     = $clog2(NUM_PASSES),
    parameter int TH_W       = $clog2(NUM_PASSES * LANES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         vote_vld_i,
    input  logic [LANES*RHO_W-1:0]   vote_rho_i,
    input  logic                     drain_start_i,
    input  logic [PASS_W-1:0]        pass_i,
    input  logic [CNT_W-1:0]         thresh_i,
    output logic                     busy_o,
    output logic                     peak_vld_o,
    output logic [TH_W-1:0]          peak_theta_o,
    output logic [RHO_W-1:0]         peak_rho_o
);
    import hv_pkg::*;

    localparam logic [RHO_W-1:0] LAST_BIN = RHO_W'(NUM_BINS - 1);

    typedef struct packed {
        hv_mode_e         mode;
        logic [RHO_W-1:0] addr;
        logic             dv;
        logic [RHO_W-1:0] drho;
    } seq_t;

    seq_t sq_d, sq_q;
    logic sweep;
    logic [LANES-1:0][CNT_W-1:0] lane_cnt;

    always_comb begin
        sq_d      = sq_q;
        sq_d.dv   = (sq_q.mode == HV_DRAIN);
        sq_d.drho = sq_q.addr;
        case (sq_q.mode)
            HV_IDLE: begin
                if (drain_start_i) begin
                    sq_d.mode = HV_DRAIN;
                    sq_d.addr = '0;
                end
            end
            default: begin
                if (sq_q.addr == LAST_BIN) begin
                    sq_d.mode = HV_IDLE;
                    sq_d.addr = '0;
                end else begin
                    sq_d.addr = sq_q.addr + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{mode: HV_INIT, addr: '0, dv: 1'b0, drho: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign sweep  = (sq_q.mode != HV_IDLE);
    assign busy_o = sweep;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [RHO_W-1:0] rho_l;
        logic             en_l;
        assign rho_l = vote_rho_i[l*RHO_W +: RHO_W];
        assign en_l  = vote_vld_i[l] && !sweep && !drain_start_i && (rho_l <= LAST_BIN);

        hv_vote_lane #(
            .NUM_BINS (NUM_BINS),
            .CNT_W    (CNT_W),
            .RHO_W    (RHO_W)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .vote_en_i    (en_l),
            .vote_rho_i   (rho_l),
            .sweep_i      (sweep),
            .sweep_addr_i (sq_q.addr),
            .rd_cnt_o     (lane_cnt[l])
        );
    end

    hv_peak_finder #(
        .LANES    (LANES),
        .NUM_BINS (NUM_BINS),
        .TILE     (TILE),
        .CNT_W    (CNT_W),
        .RHO_W    (RHO_W),
        .PASS_W   (PASS_W),
        .TH_W     (TH_W)
    ) u_peak (
        .clk          (clk),
        .rst_n        (rst_n),
        .dv_i         (sq_q.dv),
        .rho_i        (sq_q.drho),
        .cnt_i        (lane_cnt),
        .pass_i       (pass_i),
        .thresh_i     (thresh_i),
        .peak_vld_o   (peak_vld_o),
        .peak_theta_o (peak_theta_o),
        .peak_rho_o   (peak_rho_o)
    );
endmodule

// File: rtl/hv_accum_chk.sv
module hv_accum_chk #(
    parameter int LANES    = 15,
    parameter int NUM_BINS = 120,
    parameter int RHO_W    = 7,
    parameter int PASS_W   = 5,
    parameter int TH_W     = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drain_start_i,
    input logic [PASS_W-1:0] pass_i,
    input logic              busy_o,
    input logic              peak_vld_o,
    input logic [TH_W-1:0]   peak_theta_o,
    input logic [RHO_W-1:0]  peak_rho_o
);
    logic [31:0]     busy_cnt_q;
    logic [TH_W-1:0] theta_base;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
        end else if (busy_o) begin
            busy_cnt_q <= busy_cnt_q + 1;
        end else begin
            busy_cnt_q <= '0;
        end
    end

    assign theta_base = TH_W'(pass_i) * TH_W'(LANES);

    // R1, R6: each sweep lasts exactly NUM_BINS cycles
    a_r6_sweep_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> busy_cnt_q == 32'(NUM_BINS));

    // R6: a drain only begins on a request
    a_r6_start_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(drain_start_i));

    // R10: a report is a single-cycle strobe
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        peak_vld_o |=> !peak_vld_o);

    // R9: reported rho is a real bin
    a_r9_rho_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        peak_vld_o |-> 32'(peak_rho_o) < 32'(NUM_BINS));

    // R9: reported theta lies within the lanes of the current pass
    a_r9_theta_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
        peak_vld_o |-> (peak_theta_o >= theta_base) &&
                       (32'(peak_theta_o) < 32'(theta_base) + 32'(LANES)));
endmodule

bind hv_accum hv_accum_chk #(
    .LANES    (LANES),
    .NUM_BINS (NUM_BINS),
    .RHO_W    (RHO_W),
    .PASS_W   (PASS_W),
    .TH_W     (TH_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .drain_start_i (drain_start_i),
    .pass_i        (pass_i),
    .busy_o        (busy_o),
    .peak_vld_o    (peak_vld_o),
    .peak_theta_o  (peak_theta_o),
    .peak_rho_o    (peak_rho_o)
);

// File: tb/hv_accum_test.sv
`timescale 1ns/1ps
module hv_accum_test;
    localparam int LANES  = 15;
    localparam int BINS   = 120;
    localparam int TILE   = 15;
    localparam int CW     = 10;
    localparam int PASSES = 21;
    localparam int RW     = $clog2(BINS);
    localparam int PW     = $clog2(PASSES);
    localparam int TW     = $clog2(PASSES * LANES);
    localparam int CMAX   = (1 << CW) - 1;
    localparam int NT     = (BINS + TILE - 1) / TILE;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [LANES-1:0]     vote_vld = '0;
    logic [LANES*RW-1:0]  vote_rho = '0;
    logic                 drain_start = 1'b0;
    logic [PW-1:0]        pass_sel = '0;
    logic [CW-1:0]        thresh = '0;
    logic                 busy;
    logic                 peak_vld;
    logic [TW-1:0]        peak_theta;
    logic [RW-1:0]        peak_rho;

    always #5 clk = ~clk;

    hv_accum #(
        .LANES(LANES), .NUM_BINS(BINS), .TILE(TILE), .CNT_W(CW), .NUM_PASSES(PASSES)
    ) uut (
        .clk(clk), .rst_n(rst_n), .vote_vld_i(vote_vld), .vote_rho_i(vote_rho),
        .drain_start_i(drain_start), .pass_i(pass_sel), .thresh_i(thresh),
        .busy_o(busy), .peak_vld_o(peak_vld), .peak_theta_o(peak_theta), .peak_rho_o(peak_rho)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mdl [LANES][BINS];
    int cap_n = 0;
    int cap_theta [64];
    int cap_rho [64];
    int exp_n;
    int exp_theta [NT];
    int exp_rho [NT];
    bit prev_vld = 0;

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (peak_vld) begin
            if (cap_n < 64) begin
                cap_theta[cap_n] = int'(peak_theta);
                cap_rho[cap_n]   = int'(peak_rho);
            end
            cap_n++;
        end
        if (rst_n && peak_vld && prev_vld) chk(1'b0, "R10 pulse width", 2, 1);
        prev_vld = peak_vld;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_model();
        for (int l = 0; l < LANES; l++)
            for (int b = 0; b < BINS; b++) mdl[l][b] = 0;
    endtask

    // R2, R3: hold one lane's vote for n consecutive cycles
    task automatic vote(int lane, int rho, int n);
        vote_vld[lane] = 1'b1;
        vote_rho[lane*RW +: RW] = RW'(rho);
        for (int i = 0; i < n; i++) begin
            step();
            if (rho < BINS && mdl[lane][rho] < CMAX) mdl[lane][rho]++;
        end
        vote_vld = '0;
    endtask

    task automatic vote_all(int rho);
        for (int l = 0; l < LANES; l++) begin
            vote_rho[l*RW +: RW] = RW'(rho);
            mdl[l][rho]++;
        end
        vote_vld = '1;
        step();
        vote_vld = '0;
    endtask

    // expected reports from R7, R8, R9
    task automatic build_expect(int thr, int pass);
        exp_n = 0;
        for (int t = 0; t < NT; t++) begin
            int best = -1;
            int bl = 0;
            int br = 0;
            for (int r = t * TILE; r < (t + 1) * TILE && r < BINS; r++)
                for (int l = 0; l < LANES; l++)
                    if (mdl[l][r] > best) begin
                        best = mdl[l][r]; bl = l; br = r;
                    end
            if (best > thr) begin
                exp_theta[exp_n] = pass * LANES + bl;
                exp_rho[exp_n]   = br;
                exp_n++;
            end
        end
    endtask

    task automatic run_drain(int thr, int pass, bit noisy, string tag);
        int bc = 0;
        thresh = CW'(thr);
        pass_sel = PW'(pass);
        build_expect(thr, pass);
        cap_n = 0;
        drain_start = 1'b1;
        if (noisy) begin
            vote_vld[6] = 1'b1;
            vote_rho[6*RW +: RW] = RW'(60);
        end
        step();
        drain_start = 1'b0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            bc++;
            if (noisy && bc == 10) drain_start = 1'b1;
            if (noisy && bc == 11) drain_start = 1'b0;
            if (noisy && bc == BINS / 2) vote_vld = '0;
        end
        chk(bc == BINS, {tag, " R6 drain length"}, bc, BINS);
        repeat (4) @(negedge clk);
        chk(cap_n == exp_n, {tag, " R7 peak count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk(cap_theta[i] == exp_theta[i], {tag, " R9 theta"}, cap_theta[i], exp_theta[i]);
            chk(cap_rho[i] == exp_rho[i], {tag, " R10 rho order"}, cap_rho[i], exp_rho[i]);
        end
        clear_model();
    endtask

    task automatic t_reset();
        int bc = 0;
        clear_model();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy after reset", int'(busy), 1);
        while (busy) begin
            bc++;
            @(negedge clk);
        end
        chk(bc == BINS, "R1 clear length", bc, BINS);
        repeat (3) @(negedge clk);
        chk(cap_n == 0, "R1 no peak during clear", cap_n, 0);
        step();
        run_drain(0, 0, 0, "R1 empty");
    endtask

    task automatic t_basic();
        vote(3, 5, 1); vote(7, 20, 1); vote(3, 5, 1); vote(0, 40, 1);
        vote(7, 20, 1); vote(3, 5, 2);
        vote(9, 119, 1);
        run_drain(0, 2, 0, "R2 basic");
    endtask

    task automatic t_b2b();
        vote(5, 100, 6);
        vote(2, 10, 5);
        vote_all(70);
        vote_all(70);
        run_drain(5, 4, 0, "R3 b2b");
        vote(2, 10, 5);
        vote(13, 50, 3);
        run_drain(2, 4, 0, "R7 strict");
    endtask

    task automatic t_tie();
        vote(9, 30, 3); vote(4, 31, 3); vote(4, 30, 3);
        vote(8, 50, 3); vote(8, 47, 3); vote(12, 47, 3);
        run_drain(0, 7, 0, "R8 tie");
    endtask

    task automatic t_ignore();
        vote(0, 125, 3);
        vote(1, 127, 2);
        vote(10, 90, 2);
        run_drain(0, 1, 1, "R5 noisy");
        run_drain(0, 1, 0, "R5 after");
    endtask

    task automatic t_sat();
        vote(11, 77, 1030);
        vote(12, 78, 4);
        run_drain(1022, 20, 0, "R4 sat");
        vote(11, 77, 1025);
        run_drain(1023, 20, 0, "R4 ceiling");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_basic();
        t_b2b();
        t_tie();
        t_ignore();
        t_sat();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule